// File: doc/BRIEF.md
# Matrix Remap Index Generator

This block walks a flat vector of elements as if it were a one-, two- or three-dimensional array, without moving any data. After a start pulse it latches a shape (three dimension sizes of any value from 1 to 63), a loop ordering, a per-dimension reversal mask, a dimension-drop selector and a base offset. It then produces one reordered element index per accepted handshake beat and flags the final one. A consumer such as an issue stage uses the index to pick register-file elements, so transposes, rotations, reversals, repeated and modulo index patterns all come from the same engine.

Each dimension has a step counter. The loop ordering picks which dimension steps fastest, which is next, and which is slowest. A counter only advances when every faster counter wraps. The index is the offset plus, for each dimension that is not dropped, its effective count multiplied by that dimension's stride. The x stride is 1. The y stride is the x size. The z stride is the x size times the y size. Any dropped dimension counts as size 1 in these stride products. The number of beats is the product of the three sizes, capped at 127. The cap is reported on a flag.

Top module: `mtx_remap_gen`

## Requirements
- R1: After reset `outValid`, `outLast` and `cfgClamped` are low.
- R2: All shape inputs are captured on the cycle `start` is seen while idle. Changes to them while a run is in progress, and `start` pulses during a run, have no effect on that run's indices.
- R3: With ordering code 0, no reversal and no drop, the run yields the indices 0, 1, … N-1 in order. This holds for sizes that are not powers of two; a 3 by 5 shape gives 0 to 14.
- R4: A size input of 0 behaves exactly as a size of 1.
- R5: `orderSel` picks the dimension order from fastest to slowest: 0 = x,y,z; 1 = x,z,y; 2 = y,x,z; 3 = y,z,x; 4 = z,x,y; 5 = z,y,x. Codes 6 and 7 act as 0. Strides do not depend on the order, so code 2 on an x-by-y shape walks its transpose.
- R6: `mirrorSel` bit 0, 1 or 2 reverses x, y or z respectively. The effective count becomes size-1-count.
- R7: `skipSel` 1, 2 or 3 drops x, y or z from the index sum and from the stride products; 0 drops nothing. A 3x3x1 shape with code 1 gives 0,0,0,1,1,1,2,2,2. A 3x1x3 shape with code 3 gives 0,1,2,0,1,2,0,1,2.
- R8: `offsetIn` is added to every index of the run. It may differ between consecutive runs.
- R9: While `outValid` is high and `outReady` is low, `outIndex` and `outLast` hold their values. Exactly one index is consumed per cycle in which both are high.
- R10: `outLast` is high only together with the final index of a run. After that index is accepted, `outValid` falls on the next cycle.
- R11: The run has min(sx·sy·sz, 127) beats. `cfgClamped` is high from the first beat onward, until the next start, exactly when the product exceeds 127.
- R12: Three-dimensional shapes with all three sizes above 1 walk all three levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run using the shape inputs (ignored while running) |
| sizeX | input | 6 | x dimension size, 0 treated as 1 |
| sizeY | input | 6 | y dimension size, 0 treated as 1 |
| sizeZ | input | 6 | z dimension size, 0 treated as 1 |
| orderSel | input | 3 | Loop ordering code |
| mirrorSel | input | 3 | Per-dimension reversal mask (bit0 x, bit1 y, bit2 z) |
| skipSel | input | 2 | Dropped dimension (0 none, 1 x, 2 y, 3 z) |
| offsetIn | input | 8 | Base added to every index |
| outReady | input | 1 | Consumer accepts the current index |
| outValid | output | 1 | An index is presented |
| outIndex | output | 19 | Remapped element index |
| outLast | output | 1 | Current index is the final one of the run |
| cfgClamped | output | 1 | Shape product exceeded 127 and the run was cut |

## Verification
The assertions check the handshake on every cycle: the index and last flag hold through a stall, the last flag never appears without valid, valid drops right after the final beat, a run only begins after a start pulse, and no run exceeds 127 accepted beats. The bench scenarios carry the index values themselves. These include the ordering table, reversal, the dropped-dimension repeat and modulo patterns, the offset, size zero, and the exact beat count around the 127 cap. A behavioural nested-loop model in the bench produces the expected sequence for each of them. The same scenarios show that inputs changed mid-run are ignored.

// File: rtl/mtx_remap_pkg.sv
package mtx_remap_pkg;

  typedef struct packed {
    logic load;
    logic step;
  } ctlStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } runState_t;

  // returns {slowDim, midDim, fastDim}, 0=x 1=y 2=z
  function automatic logic [5:0] orderMap(input logic [2:0] code);
    logic [5:0] m;
    case (code)
      3'd1:    m = {2'd1, 2'd2, 2'd0};
      3'd2:    m = {2'd2, 2'd0, 2'd1};
      3'd3:    m = {2'd0, 2'd2, 2'd1};
      3'd4:    m = {2'd1, 2'd0, 2'd2};
      3'd5:    m = {2'd0, 2'd1, 2'd2};
      default: m = {2'd2, 2'd1, 2'd0};
    endcase
    return m;
  endfunction

  function automatic logic [2:0] skipDecode(input logic [1:0] code);
    logic [2:0] h;
    case (code)
      2'd1:    h = 3'b001;
      2'd2:    h = 3'b010;
      2'd3:    h = 3'b100;
      default: h = 3'b000;
    endcase
    return h;
  endfunction

endpackage

// File: rtl/mtx_remap_ctrl.sv
module mtx_remap_ctrl
  import mtx_remap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       outReady,
  input  logic       isLast,
  output ctlStrobe_t ctl,
  output logic       running
);

  runState_t st, stNext;

  always_comb begin
    ctl.load = (st == ST_IDLE) && start;
    ctl.step = (st == ST_RUN) && outReady;
    stNext   = st;
    if (ctl.load) stNext = ST_RUN;
    else if (ctl.step && isLast) stNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  assign running = (st == ST_RUN);

endmodule

// File: rtl/mtx_remap_dp.sv
module mtx_remap_dp
  import mtx_remap_pkg::*;
#(
  parameter int SIZE_W  = 6,
  parameter int OFS_W   = 8,
  parameter int MAX_LEN = 127
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          ctl,
  input  logic [SIZE_W-1:0]   sizeX,
  input  logic [SIZE_W-1:0]   sizeY,
  input  logic [SIZE_W-1:0]   sizeZ,
  input  logic [2:0]          orderSel,
  input  logic [2:0]          mirrorSel,
  input  logic [1:0]          skipSel,
  input  logic [OFS_W-1:0]    offsetIn,
  output logic [((OFS_W > 3*SIZE_W) ? OFS_W : 3*SIZE_W):0] index,
  output logic                isLast,
  output logic                clamped
);

  localparam int IDX_W  = ((OFS_W > 3*SIZE_W) ? OFS_W : 3*SIZE_W) + 1;
  localparam int LEN_W  = $clog2(MAX_LEN + 1);
  localparam int STR_W  = 2 * SIZE_W;
  localparam int PROD_W = 3 * SIZE_W;
  localparam int NDIM   = 3;

  // shape as presented at the inputs
  logic [SIZE_W-1:0] sizeIn   [NDIM];
  logic [STR_W-1:0]  strideIn [NDIM];
  logic [STR_W-1:0]  spanX, spanY;
  logic [PROD_W-1:0] prodIn;
  logic              overIn;
  logic [LEN_W-1:0]  lenIn;
  logic [2:0]        skipIn;
  logic [5:0]        mapIn;

  // latched run state
  logic [SIZE_W-1:0] sizeQ   [NDIM];
  logic [SIZE_W-1:0] cntQ    [NDIM];
  logic [SIZE_W-1:0] cntD    [NDIM];
  logic [STR_W-1:0]  strideQ [NDIM];
  logic [1:0]        lvlQ    [NDIM];
  logic [2:0]        mirQ, skipQ;
  logic [OFS_W-1:0]  offQ;
  logic [LEN_W-1:0]  lenQ, elemQ;
  logic              clampQ;
  logic [IDX_W-1:0]  term    [NDIM];

  always_comb begin
    sizeIn[0] = (sizeX == '0) ? SIZE_W'(1) : sizeX;
    sizeIn[1] = (sizeY == '0) ? SIZE_W'(1) : sizeY;
    sizeIn[2] = (sizeZ == '0) ? SIZE_W'(1) : sizeZ;
  end

  assign skipIn = skipDecode(skipSel);
  assign mapIn  = orderMap(orderSel);
  assign prodIn = PROD_W'(sizeIn[0]) * PROD_W'(sizeIn[1]) * PROD_W'(sizeIn[2]);
  assign overIn = prodIn > PROD_W'(MAX_LEN);
  assign lenIn  = overIn ? LEN_W'(MAX_LEN) : prodIn[LEN_W-1:0];

  // a dropped dimension contributes size 1 to slower strides
  assign spanX = skipIn[0] ? STR_W'(1) : STR_W'(sizeIn[0]);
  assign spanY = skipIn[1] ? STR_W'(1) : STR_W'(sizeIn[1]);

  always_comb begin
    strideIn[0] = STR_W'(1);
    strideIn[1] = spanX;
    strideIn[2] = spanX * spanY;
  end

  // nested counter advance, fastest level first
  always_comb begin
    logic carry;
    carry = 1'b1;
    for (int d = 0; d < NDIM; d++) cntD[d] = cntQ[d];
    for (int l = 0; l < NDIM; l++) begin
      if (carry) begin
        if (cntQ[lvlQ[l]] == sizeQ[lvlQ[l]] - SIZE_W'(1)) begin
          cntD[lvlQ[l]] = '0;
        end else begin
          cntD[lvlQ[l]] = cntQ[lvlQ[l]] + SIZE_W'(1);
          carry = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int d = 0; d < NDIM; d++) begin
        sizeQ[d]   <= SIZE_W'(1);
        cntQ[d]    <= '0;
        strideQ[d] <= '0;
        lvlQ[d]    <= 2'(d);
      end
      mirQ   <= '0;
      skipQ  <= '0;
      offQ   <= '0;
      lenQ   <= LEN_W'(1);
      elemQ  <= '0;
      clampQ <= 1'b0;
    end else if (ctl.load) begin
      for (int d = 0; d < NDIM; d++) begin
        sizeQ[d]   <= sizeIn[d];
        cntQ[d]    <= '0;
        strideQ[d] <= strideIn[d];
        lvlQ[d]    <= mapIn[2*d +: 2];
      end
      mirQ   <= mirrorSel;
      skipQ  <= skipIn;
      offQ   <= offsetIn;
      lenQ   <= lenIn;
      elemQ  <= '0;
      clampQ <= overIn;
    end else if (ctl.step) begin
      for (int d = 0; d < NDIM; d++) cntQ[d] <= cntD[d];
      elemQ <= elemQ + LEN_W'(1);
    end
  end

  for (genvar g = 0; g < NDIM; g++) begin : gTerm
    logic [SIZE_W-1:0] eff;
    assign eff     = mirQ[g] ? (sizeQ[g] - SIZE_W'(1) - cntQ[g]) : cntQ[g];
    assign term[g] = skipQ[g] ? '0 : IDX_W'(eff) * IDX_W'(strideQ[g]);
  end

  assign index   = IDX_W'(offQ) + term[0] + term[1] + term[2];
  assign isLast  = (elemQ == lenQ - LEN_W'(1));
  assign clamped = clampQ;

endmodule

// File: rtl/mtx_remap_gen.sv
module mtx_remap_gen
  import mtx_remap_pkg::*;
#(
  parameter int SIZE_W  = 6,
  parameter int OFS_W   = 8,
  parameter int MAX_LEN = 127
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [SIZE_W-1:0] sizeX,
  input  logic [SIZE_W-1:0] sizeY,
  input  logic [SIZE_W-1:0] sizeZ,
  input  logic [2:0]        orderSel,
  input  logic [2:0]        mirrorSel,
  input  logic [1:0]        skipSel,
  input  logic [OFS_W-1:0]  offsetIn,
  input  logic              outReady,
  output logic              outValid,
  output logic [((OFS_W > 3*SIZE_W) ? OFS_W : 3*SIZE_W):0] outIndex,
  output logic              outLast,
  output logic              cfgClamped
);

  ctlStrobe_t ctl;
  logic       isLast;
  logic       running;

  mtx_remap_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .outReady (outReady),
    .isLast   (isLast),
    .ctl      (ctl),
    .running  (running)
  );

  mtx_remap_dp #(
    .SIZE_W  (SIZE_W),
    .OFS_W   (OFS_W),
    .MAX_LEN (MAX_LEN)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .sizeX     (sizeX),
    .sizeY     (sizeY),
    .sizeZ     (sizeZ),
    .orderSel  (orderSel),
    .mirrorSel (mirrorSel),
    .skipSel   (skipSel),
    .offsetIn  (offsetIn),
    .index     (outIndex),
    .isLast    (isLast),
    .clamped   (cfgClamped)
  );

  assign outValid = running;
  assign outLast  = running && isLast;

endmodule

// File: rtl/mtx_remap_chk.sv
module mtx_remap_chk #(
  parameter int SIZE_W  = 6,
  parameter int OFS_W   = 8,
  parameter int MAX_LEN = 127
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic outReady,
  input logic outValid,
  input logic outLast,
  input logic [((OFS_W > 3*SIZE_W) ? OFS_W : 3*SIZE_W):0] outIndex
);

  logic [15:0] beatCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !outValid) beatCnt <= '0;
    else if (outReady)      beatCnt <= beatCnt + 16'd1;
  end

  p_last_with_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outIndex) && $stable(outLast)));

  p_end_after_last_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> !outValid);

  p_run_needs_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(start));

  p_len_cap_r11: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (beatCnt < 16'(MAX_LEN)));

endmodule

bind mtx_remap_gen mtx_remap_chk #(
  .SIZE_W  (SIZE_W),
  .OFS_W   (OFS_W),
  .MAX_LEN (MAX_LEN)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .outReady (outReady),
  .outValid (outValid),
  .outLast  (outLast),
  .outIndex (outIndex)
);

// File: tb/sim_mtx_remap_gen.sv
`timescale 1ns/1ps
module sim_mtx_remap_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  sizeX = '0, sizeY = '0, sizeZ = '0;
  logic [2:0]  orderSel = '0, mirrorSel = '0;
  logic [1:0]  skipSel = '0;
  logic [7:0]  offsetIn = '0;
  logic        outReady = 1'b0;
  logic        outValid, outLast, cfgClamped;
  logic [18:0] outIndex;

  int checks = 0;
  int errors = 0;
  int expQ[$];
  bit clampExp;

  always #2 clk = ~clk;

  mtx_remap_gen u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .sizeX(sizeX), .sizeY(sizeY), .sizeZ(sizeZ),
    .orderSel(orderSel), .mirrorSel(mirrorSel), .skipSel(skipSel),
    .offsetIn(offsetIn), .outReady(outReady),
    .outValid(outValid), .outIndex(outIndex), .outLast(outLast),
    .cfgClamped(cfgClamped)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // nested-loop reference
  task automatic buildModel(input int sx, input int sy, input int sz,
                            input int ord, input int mir, input int skp,
                            input int ofs);
    int s[3];
    int lv[3];
    int str[3];
    int c[3];
    s[0] = (sx == 0) ? 1 : sx;
    s[1] = (sy == 0) ? 1 : sy;
    s[2] = (sz == 0) ? 1 : sz;
    case (ord)
      1: lv = '{0, 2, 1};
      2: lv = '{1, 0, 2};
      3: lv = '{1, 2, 0};
      4: lv = '{2, 0, 1};
      5: lv = '{2, 1, 0};
      default: lv = '{0, 1, 2};
    endcase
    str[0] = 1;
    str[1] = (skp == 1) ? 1 : s[0];
    str[2] = str[1] * ((skp == 2) ? 1 : s[1]);
    expQ.delete();
    for (int a2 = 0; a2 < s[lv[2]]; a2++)
      for (int a1 = 0; a1 < s[lv[1]]; a1++)
        for (int a0 = 0; a0 < s[lv[0]]; a0++) begin
          int idx;
          c[lv[0]] = a0; c[lv[1]] = a1; c[lv[2]] = a2;
          idx = ofs;
          for (int d = 0; d < 3; d++)
            if (skp != d + 1)
              idx += (mir[d] ? (s[d] - 1 - c[d]) : c[d]) * str[d];
          if (expQ.size() < 127) expQ.push_back(idx);
        end
    clampExp = (s[0] * s[1] * s[2]) > 127;
  endtask

  task automatic runCase(input string req, input int sx, input int sy, input int sz,
                         input int ord, input int mir, input int skp, input int ofs,
                         input int rdyMode, input bit disturb);
    int cyc;
    bit rdy;
    buildModel(sx, sy, sz, ord, mir, skp, ofs);
    @(negedge clk);
    sizeX = 6'(sx); sizeY = 6'(sy); sizeZ = 6'(sz);
    orderSel = 3'(ord); mirrorSel = 3'(mir); skipSel = 2'(skp);
    offsetIn = 8'(ofs); start = 1'b1; outReady = 1'b0;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (cyc < 2000) begin
      check(outValid == (expQ.size() > 0), req, "valid", int'(outValid),
            int'(expQ.size() > 0));
      if (expQ.size() == 0) break;
      if (outValid) begin
        check(int'(outIndex) == expQ[0], req, "index", int'(outIndex), expQ[0]);
        check(outLast == (expQ.size() == 1), req, "last", int'(outLast),
              int'(expQ.size() == 1));
      end
      case (rdyMode)
        1: rdy = (cyc % 3) != 1;
        2: rdy = (cyc % 4) < 2;
        default: rdy = 1'b1;
      endcase
      outReady = rdy;
      if (rdy && outValid) void'(expQ.pop_front());
      if (disturb && cyc == 2) begin
        // R2: new shape and a start pulse mid-run must be ignored
        start = 1'b1; sizeX = 6'd9; sizeY = 6'd1; sizeZ = 6'd1;
        mirrorSel = 3'b111; skipSel = 2'd1; offsetIn = 8'd77; orderSel = 3'd5;
      end else begin
        start = 1'b0;
      end
      cyc++;
      @(negedge clk);
    end
    check(cyc < 2000, req, "run length", cyc, 2000);
    check(cfgClamped == clampExp, req, "clamped", int'(cfgClamped), int'(clampExp));
    start = 1'b0;
    outReady = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1", "reset valid", int'(outValid), 0);
    check(outLast == 1'b0, "R1", "reset last", int'(outLast), 0);
    check(cfgClamped == 1'b0, "R1", "reset clamped", int'(cfgClamped), 0);

    runCase("R3", 3, 5, 1, 0, 0, 0, 0, 0, 1'b0);
    runCase("R12", 3, 2, 4, 0, 0, 0, 0, 1, 1'b0);
    runCase("R5", 3, 4, 1, 2, 0, 0, 0, 2, 1'b0);
    runCase("R5", 2, 3, 2, 5, 0, 0, 0, 0, 1'b0);
    runCase("R5", 2, 3, 4, 3, 0, 0, 0, 1, 1'b0);
    runCase("R5", 2, 3, 2, 7, 0, 0, 0, 0, 1'b0);
    runCase("R6", 4, 3, 1, 0, 1, 0, 0, 0, 1'b0);
    runCase("R6", 2, 3, 2, 4, 6, 0, 0, 1, 1'b0);
    runCase("R7", 3, 3, 1, 0, 0, 1, 0, 0, 1'b0);
    runCase("R7", 3, 1, 3, 0, 0, 3, 0, 2, 1'b0);
    runCase("R7", 2, 3, 2, 1, 0, 2, 0, 0, 1'b0);
    runCase("R8", 5, 7, 1, 0, 2, 0, 200, 1, 1'b0);
    runCase("R8", 5, 7, 1, 0, 2, 0, 13, 0, 1'b0);
    runCase("R4", 0, 4, 0, 0, 0, 0, 0, 0, 1'b0);
    runCase("R11", 7, 7, 7, 0, 0, 0, 0, 0, 1'b0);
    runCase("R11", 7, 6, 3, 1, 0, 0, 0, 1, 1'b0);
    runCase("R11", 8, 4, 4, 0, 5, 0, 3, 0, 1'b0);
    runCase("R2", 4, 3, 2, 0, 0, 0, 5, 1, 1'b1);
    runCase("R9", 3, 3, 3, 3, 1, 0, 0, 2, 1'b0);
    runCase("R10", 1, 1, 1, 0, 0, 0, 9, 2, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule